// File: doc/BRIEF.md
# Prescaled RTC Wakeup Timer

A periodic wakeup timer that runs from the RTC clock. A binary prescaler divides the clock by 2, 4, 8 or 16. Each divided tick decrements a 16-bit counter. When the counter passes zero, three things happen: a sticky wakeup flag is set, a one-cycle event pulse goes out toward an external interrupt controller, and the counter reloads by itself. A level interrupt output shows the flag when the interrupt enable is set.

Software disables the timer before it changes the reload value or the divider. It then waits for a write-allowed flag, which follows the enable through a short synchroniser. Any configuration write made while that flag is low is dropped. The stored configuration can always be read back on dedicated output ports.

Top module: `rtc_wakeup_timer`

## Requirements
- R1: `cfg_sel_i` selects the tick divider as 2^(sel+1) RTC clocks: 0 gives ÷2, 1 gives ÷4, 2 gives ÷8 and 3 gives ÷16.
- R2: The enable is written with `ctrl_we_i` and `ctrl_en_i`=1 in cycle c. The first expiry is then visible in cycle c+2+(reload+1)·div. Further expiries follow every (reload+1)·div cycles without any software action.
- R3: `wake_pulse_o` is high for exactly one clock for each expiry and is low at all other times.
- R4: `flag_o` is set on expiry and stays set until a `flag_clr_i` strobe clears it. Disabling the timer does not clear it.
- R5: `irq_o` equals `flag_o` AND the interrupt enable that was last written through `ctrl_ie_i`.
- R6: `wr_ok_o` is low from the cycle after the enable is written. After a disable, it returns high 3 cycles after the disabling write, never sooner.
- R7: A configuration write (`cfg_we_i`) is stored only when `wr_ok_o` is 1. Otherwise `sel_o` and `reload_o` keep their values.
- R8: After reset the timer is disabled, `wr_ok_o`=1, `flag_o`=`irq_o`=`wake_pulse_o`=0, and `sel_o`=0, `reload_o`=0.
- R9: Once the enable has been cleared, no further expiries occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | RTC clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Write strobe for enable and interrupt enable |
| ctrl_en_i | input | 1 | Timer enable value |
| ctrl_ie_i | input | 1 | Interrupt enable value |
| cfg_we_i | input | 1 | Write strobe for divider select and reload |
| cfg_sel_i | input | 2 | Divider select |
| cfg_reload_i | input | 16 | Reload value |
| flag_clr_i | input | 1 | Clears the wakeup flag |
| wr_ok_o | output | 1 | Configuration writes allowed |
| sel_o | output | 2 | Stored divider select |
| reload_o | output | 16 | Stored reload value |
| flag_o | output | 1 | Sticky wakeup flag |
| irq_o | output | 1 | Level interrupt |
| wake_pulse_o | output | 1 | One-cycle event per expiry |

## Verification
The timer is run with four divider and reload pairs: ÷2 with reload 3, ÷16 with reload 0, ÷4 with reload 2 and ÷8 with reload 1. Two of these give the same 16-cycle period from different factors, so a swapped divider decode or an off-by-one in the reload count shows up as a shifted pulse time in the scoreboard. Every run tries one configuration write while the timer is enabled and another while the write-allowed flag is still low after the disable; both must be dropped. One run has the interrupt enable clear, which separates the flag from the interrupt. A quiet window after each disable catches any pulse that should no longer occur.

// File: rtl/rtc_wkup_pkg.sv
package rtc_wkup_pkg;
  localparam int PRESC_W = 4;

  typedef enum logic [1:0] {
    DIV2  = 2'd0,
    DIV4  = 2'd1,
    DIV8  = 2'd2,
    DIV16 = 2'd3
  } div_sel_e;

  function automatic logic [PRESC_W-1:0] div_last(div_sel_e s);
    case (s)
      DIV2:    return PRESC_W'(1);
      DIV4:    return PRESC_W'(3);
      DIV8:    return PRESC_W'(7);
      default: return PRESC_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/wkup_regs.sv
module wkup_regs #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ctrl_we_i,
  input  logic                    ctrl_en_i,
  input  logic                    ctrl_ie_i,
  input  logic                    cfg_we_i,
  input  rtc_wkup_pkg::div_sel_e  cfg_sel_i,
  input  logic [CNT_W-1:0]        cfg_reload_i,
  input  logic                    flag_clr_i,
  input  logic                    expire_i,
  output logic                    en_o,
  output logic                    ie_o,
  output logic                    wr_ok_o,
  output rtc_wkup_pkg::div_sel_e  sel_o,
  output logic [CNT_W-1:0]        reload_o,
  output logic                    flag_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0;
      ie_o <= 1'b0;
    end else if (ctrl_we_i) begin
      en_o <= ctrl_en_i;
      ie_o <= ctrl_ie_i;
    end
  end

  // disabled state crosses toward the register side through a short chain
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= ~en_o;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign wr_ok_o = sync_q[SYNC_STAGES-1] & ~en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o    <= rtc_wkup_pkg::DIV2;
      reload_o <= '0;
    end else if (cfg_we_i && wr_ok_o) begin
      sel_o    <= cfg_sel_i;
      reload_o <= cfg_reload_i;
    end
  end

  // a new expiry wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (expire_i)   flag_o <= 1'b1;
    else if (flag_clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/wkup_prescaler.sv
module wkup_prescaler (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  rtc_wkup_pkg::div_sel_e sel_i,
  output logic                   tick_o
);
  import rtc_wkup_pkg::*;

  logic [PRESC_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_last(sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + PRESC_W'(1);
  end
endmodule

// File: rtl/wkup_counter.sv
module wkup_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             run_o,
  output logic             expire_o,
  output logic             wake_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_o && en_i && tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      cnt_q  <= '0;
      wake_o <= 1'b0;
    end else begin
      run_o  <= en_i;
      wake_o <= expire_o;
      if (en_i && !run_o)        cnt_q <= reload_i;
      else if (expire_o)         cnt_q <= reload_i;
      else if (run_o && tick_i)  cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/rtc_wakeup_timer.sv
module rtc_wakeup_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             ctrl_en_i,
  input  logic             ctrl_ie_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [CNT_W-1:0] cfg_reload_i,
  input  logic             flag_clr_i,
  output logic             wr_ok_o,
  output logic [1:0]       sel_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             wake_pulse_o
);
  import rtc_wkup_pkg::*;

  logic     en_q, ie_q, run, tick, expire;
  div_sel_e sel_q;

  wkup_regs #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_en_i, .ctrl_ie_i, .cfg_we_i,
    .cfg_sel_i    (div_sel_e'(cfg_sel_i)),
    .cfg_reload_i,
    .flag_clr_i,
    .expire_i     (expire),
    .en_o         (en_q),
    .ie_o         (ie_q),
    .wr_ok_o,
    .sel_o        (sel_q),
    .reload_o,
    .flag_o
  );

  wkup_prescaler u_presc (
    .clk_i, .rst_ni,
    .run_i  (run),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  wkup_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i     (en_q),
    .tick_i   (tick),
    .reload_i (reload_o),
    .run_o    (run),
    .expire_o (expire),
    .wake_o   (wake_pulse_o)
  );

  assign sel_o = sel_q;
  assign irq_o = flag_o & ie_q;
endmodule

// File: rtl/rtc_wakeup_timer_chk.sv
module rtc_wakeup_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_q,
  input logic             wr_ok_o,
  input logic [CNT_W-1:0] reload_o,
  input logic [1:0]       sel_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             wake_pulse_o
);
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |=> !wake_pulse_o);

  a_r4_flag_with_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |-> flag_o);

  a_r5_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);

  a_r6_wr_ok_rise_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_ok_o) |-> !$past(en_q));

  a_r7_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> ($stable(reload_o) && $stable(sel_o)));

  a_r9_quiet_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !wake_pulse_o);
endmodule

bind rtc_wakeup_timer rtc_wakeup_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .en_q, .wr_ok_o, .reload_o, .sel_o, .flag_o, .irq_o, .wake_pulse_o
);

// File: tb/rtc_wakeup_timer_test.sv
module rtc_wakeup_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, ctrl_en = 1'b0, ctrl_ie = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_reload = '0;
  logic        flag_clr = 1'b0;
  logic        wr_ok, flag, irq, wake;
  logic [1:0]  sel_rb;
  logic [15:0] reload_rb;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int n_pulse = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_wakeup_timer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_en_i(ctrl_en), .ctrl_ie_i(ctrl_ie),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_reload_i(cfg_reload),
    .flag_clr_i(flag_clr),
    .wr_ok_o(wr_ok), .sel_o(sel_rb), .reload_o(reload_rb),
    .flag_o(flag), .irq_o(irq), .wake_pulse_o(wake)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: compare each pulse against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && wake) begin
      n_pulse++;
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected pulse", cyc, -1);
      else begin
        int t;
        t = exp_q.pop_front();
        chk(t == cyc, "R2 expiry time", cyc, t);
      end
    end
  end

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic run_case(input logic [1:0] s, input logic [15:0] r, input int n, input logic ie);
    int d, p, c, last, snap;
    d = 2 << s;          // R1 divider 2^(sel+1)
    p = (r + 1) * d;
    // configuration write while allowed
    cfg_we = 1'b1; cfg_sel = s; cfg_reload = r;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(reload_rb == r, "R7 reload stored", reload_rb, r);
    chk(sel_rb == s, "R1 select stored", sel_rb, s);
    // enable
    c = cyc;
    ctrl_we = 1'b1; ctrl_en = 1'b1; ctrl_ie = ie;
    for (int k = 0; k < n; k++) exp_q.push_back(c + 2 + (k + 1) * p);
    last = c + 1 + n * p + 1;
    @(negedge clk);
    ctrl_we = 1'b0;
    chk(wr_ok == 1'b0, "R6 wr_ok low after enable", wr_ok, 0);
    // write while enabled must be dropped
    cfg_we = 1'b1; cfg_reload = r ^ 16'h00f0; cfg_sel = ~s;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(reload_rb == r, "R7 reload locked while enabled", reload_rb, r);
    wait_cyc(last);
    chk(flag == 1'b1, "R4 flag set", flag, 1);
    chk(irq == ie, "R5 irq gating", irq, ie);
    // disable
    ctrl_we = 1'b1; ctrl_en = 1'b0; ctrl_ie = ie;
    @(negedge clk);
    ctrl_we = 1'b0;
    chk(wr_ok == 1'b0, "R6 wr_ok still low", wr_ok, 0);
    cfg_we = 1'b1; cfg_reload = 16'h1234;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(reload_rb == r, "R7 write dropped while wr_ok low", reload_rb, r);
    chk(wr_ok == 1'b0, "R6 wr_ok not early", wr_ok, 0);
    @(negedge clk);
    chk(wr_ok == 1'b1, "R6 wr_ok back high", wr_ok, 1);
    chk(flag == 1'b1, "R4 flag kept after disable", flag, 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(flag == 1'b0, "R4 flag cleared", flag, 0);
    chk(irq == 1'b0, "R5 irq follows flag", irq, 0);
    snap = n_pulse;
    repeat (2 * p + 4) @(negedge clk);
    chk(n_pulse == snap, "R9 no pulse after disable", n_pulse, snap);
    chk(exp_q.size() == 0, "R2 missing expiries", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ok == 1'b1, "R8 wr_ok reset", wr_ok, 1);
    chk(flag == 1'b0, "R8 flag reset", flag, 0);
    chk(irq == 1'b0, "R8 irq reset", irq, 0);
    chk(wake == 1'b0, "R8 pulse reset", wake, 0);
    chk(reload_rb == 16'd0 && sel_rb == 2'd0, "R8 config reset", reload_rb, 0);
    run_case(2'd0, 16'd3, 3, 1'b1);
    run_case(2'd3, 16'd0, 2, 1'b0);
    run_case(2'd1, 16'd2, 3, 1'b1);
    run_case(2'd2, 16'd1, 2, 1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule